// File: doc/BRIEF.md
# Prioritised Converter Interrupt Vector Generator

This block gathers the interrupt sources of a multi-entry data converter into one request line and a read-only vector word. There is one visible pending flag per result entry, plus two hidden conditions: result overrun and conversion-time overflow. The hidden conditions have no flag bits. A software handler reads the vector, jumps on its value and services the source that the vector names.

Flags set when the result memory writes an entry. They clear when that entry is read back, or when software writes the flag register. The block watches the result-memory write and read strobes to track which entries hold unread data. A write to an unread entry raises the overrun condition. Any access to the vector word clears a hidden condition, but only if that condition is the source the vector currently reports. The vector is recomputed combinationally every cycle from the set of sources that are both pending and enabled.

Top module: `cvt_irq_vector`

## Requirements
- R1: After a synchronous active-low reset, the flag register, the enable register and both hidden conditions are zero. The vector reads 0x0000 and the request is low.
- R2: The vector word is 0x0000 when nothing enabled is pending. It is 0x0002 for overrun, 0x0004 for conversion-time overflow, and 0x0006 + 2*n for result flag n (0x0024 for n = 15).
- R3: When several enabled sources are pending, the vector names the highest-priority one. Overrun ranks first, then conversion-time overflow, then flag 0 through flag 15, with flag 15 lowest.
- R4: A pending source whose enable is clear does not change the vector. The enables are bit n of the enable register for flag n, `ovr_ie_i` for overrun and `tov_ie_i` for timing overflow. The source takes effect in the same cycle that its enable rises.
- R5: A result write to entry n sets flag n on the next clock. A result write takes precedence over a same-cycle read of that entry and over a same-cycle software write of the flag register.
- R6: Flag n clears on the next clock after a result read of entry n. A software write loads the flag register from `flg_wdata_i`, so writing 0 to bit n clears flag n.
- R7: A result write to an entry whose previous result has not been read raises the overrun condition on the next clock. A read of the same entry in the same cycle counts as happening first. Clearing a flag by software does not mark its result as read.
- R8: A one-cycle pulse on `tov_evt_i` raises the conversion-time overflow condition on the next clock.
- R9: A vector access (`vec_acc_i`) clears overrun or timing overflow on the next clock, but only if that condition is the source reported in the access cycle. A new event for that condition in the same cycle keeps it set. A vector access never changes the result flags.
- R10: `irq_o` is high exactly when `gie_i` is high and at least one enabled source is pending. It therefore stays high while other sources remain pending after one has been serviced.
- R11: A write strobe `en_wr_i` loads the enable register from `en_wdata_i` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| ovr_ie_i | input | 1 | Enable for the overrun condition |
| tov_ie_i | input | 1 | Enable for the conversion-time overflow condition |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_RES | Enable register write data |
| en_q_o | output | NUM_RES | Enable register contents |
| flg_wr_i | input | 1 | Flag register software write strobe |
| flg_wdata_i | input | NUM_RES | Flag register write data |
| flag_q_o | output | NUM_RES | Per-result pending flags |
| res_wr_i | input | 1 | Result memory write strobe |
| res_wr_idx_i | input | IDX_W | Entry written by the result memory |
| res_rd_i | input | 1 | Result memory read strobe |
| res_rd_idx_i | input | IDX_W | Entry read from the result memory |
| tov_evt_i | input | 1 | Conversion-time overflow event pulse |
| vec_acc_i | input | 1 | Vector word access (read or write) |
| vec_q_o | output | 16 | Interrupt vector word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two kinds of event can fall in the same cycle: a vector access that clears a hidden condition, and a new event that raises that condition again. A result write and a result read can also hit the same entry in one cycle. The bench drives these pairs in directed steps. It then judges the outcome one clock later: the condition must stay set and the vector must hold its code, and for the same-entry pair the flag must be set with no overrun. During a long random phase, the strobes, software writes and enable changes land freely on top of one another. A behavioural reference model applies the stated ordering every clock and is compared with the vector, the request, the flags and the enables.

// File: rtl/cvt_irq_pkg.sv
// Shared definitions for the converter interrupt vector generator.
// Assumes a 16-bit vector word and even-valued source codes.
package cvt_irq_pkg;
    localparam int VEC_W     = 16;
    localparam int FLAG_BASE = 6;
    localparam int FLAG_STEP = 2;

    typedef logic [VEC_W-1:0] vec_t;

    localparam vec_t CODE_NONE = vec_t'(0);
    localparam vec_t CODE_OVR  = vec_t'(2);
    localparam vec_t CODE_TOV  = vec_t'(4);

    // Hidden condition slots in the sticky-condition array
    localparam int HID_OVR = 0;
    localparam int HID_TOV = 1;
    localparam int HID_NUM = 2;

    // Vector code for result flag n
    function automatic vec_t flag_code(input int n);
        return vec_t'(FLAG_BASE + FLAG_STEP * n);
    endfunction
endpackage

// File: rtl/cvt_irq_result_track.sv
// Result-flag bank and unread tracker.
// Keeps one pending flag and one unread marker per result entry, and
// reports an overrun event when an unread entry is written again.
// Assumes at most one result write and one result read per cycle.
module cvt_irq_result_track #(
    parameter  int NUM_RES = 16,
    localparam int IDX_W   = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_wr_i,
    input  logic [IDX_W-1:0]   res_wr_idx_i,
    input  logic               res_rd_i,
    input  logic [IDX_W-1:0]   res_rd_idx_i,
    input  logic               flg_wr_i,
    input  logic [NUM_RES-1:0] flg_wdata_i,
    output logic [NUM_RES-1:0] flag_q_o,
    output logic               ovr_evt_o
);
    logic [NUM_RES-1:0] wr_hit, rd_hit, ovr_hit;
    logic [NUM_RES-1:0] flag_q, flag_d, unread_q, unread_d;

    // Decode the strobes into per-entry hits and compute next state
    always_comb begin
        for (int i = 0; i < NUM_RES; i++) begin
            wr_hit[i]   = res_wr_i && (res_wr_idx_i == IDX_W'(i));
            rd_hit[i]   = res_rd_i && (res_rd_idx_i == IDX_W'(i));
            ovr_hit[i]  = wr_hit[i] && unread_q[i] && !rd_hit[i];
            unread_d[i] = wr_hit[i] ? 1'b1 : (rd_hit[i] ? 1'b0 : unread_q[i]);
            if (wr_hit[i])
                flag_d[i] = 1'b1;
            else if (rd_hit[i])
                flag_d[i] = 1'b0;
            else if (flg_wr_i)
                flag_d[i] = flg_wdata_i[i];
            else
                flag_d[i] = flag_q[i];
        end
    end

    // Register the flag bank and the unread markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= '0;
            unread_q <= '0;
        end else begin
            flag_q   <= flag_d;
            unread_q <= unread_d;
        end
    end

    assign flag_q_o  = flag_q;
    assign ovr_evt_o = |ovr_hit;
endmodule

// File: rtl/cvt_irq_sticky.sv
// One hidden sticky condition: set by an event, cleared when serviced.
// A set in the same cycle as a clear wins, so no event is lost.
module cvt_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // Hold the condition until it is serviced
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i | (q & ~clr_i);
    end

    assign q_o = q;
endmodule

// File: rtl/cvt_irq_prio_enc.sv
// Fixed-priority encoder for the vector word.
// Order: overrun, timing overflow, then flags 0 (high) to NUM_RES-1 (low).
// Inputs are already masked by their enables.
module cvt_irq_prio_enc
    import cvt_irq_pkg::*;
#(
    parameter int NUM_RES = 16
) (
    input  logic               ovr_act_i,
    input  logic               tov_act_i,
    input  logic [NUM_RES-1:0] flg_act_i,
    output vec_t               vec_o,
    output logic               sel_ovr_o,
    output logic               sel_tov_o,
    output logic               any_o
);
    // Walk from lowest to highest priority so the last hit wins
    always_comb begin
        vec_o = CODE_NONE;
        for (int i = NUM_RES - 1; i >= 0; i--) begin
            if (flg_act_i[i]) vec_o = flag_code(i);
        end
        if (tov_act_i) vec_o = CODE_TOV;
        if (ovr_act_i) vec_o = CODE_OVR;
    end

    // Select lines for servicing the hidden conditions
    always_comb begin
        sel_ovr_o = ovr_act_i;
        sel_tov_o = tov_act_i && !ovr_act_i;
        any_o     = ovr_act_i || tov_act_i || (|flg_act_i);
    end
endmodule

// File: rtl/cvt_irq_vector.sv
// Top of the converter interrupt vector generator.
// Holds the enable register, masks the sources, encodes the vector and
// clears a hidden condition when a vector access reports it.
// Assumes NUM_RES >= 2 and that the largest code fits the vector word.
module cvt_irq_vector
    import cvt_irq_pkg::*;
#(
    parameter  int NUM_RES = 16,
    localparam int IDX_W   = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie_i,
    input  logic               ovr_ie_i,
    input  logic               tov_ie_i,
    input  logic               en_wr_i,
    input  logic [NUM_RES-1:0] en_wdata_i,
    output logic [NUM_RES-1:0] en_q_o,
    input  logic               flg_wr_i,
    input  logic [NUM_RES-1:0] flg_wdata_i,
    output logic [NUM_RES-1:0] flag_q_o,
    input  logic               res_wr_i,
    input  logic [IDX_W-1:0]   res_wr_idx_i,
    input  logic               res_rd_i,
    input  logic [IDX_W-1:0]   res_rd_idx_i,
    input  logic               tov_evt_i,
    input  logic               vec_acc_i,
    output logic [VEC_W-1:0]   vec_q_o,
    output logic               irq_o
);
    logic [NUM_RES-1:0] en_q, flag_q, flg_act;
    logic               ovr_evt;
    logic [HID_NUM-1:0] hid_set, hid_clr, hid_q, hid_ie, hid_sel;
    logic               any_act;
    vec_t               vec;

    // Enable register, loaded by its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    cvt_irq_result_track #(.NUM_RES(NUM_RES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_wr_i     (res_wr_i),
        .res_wr_idx_i (res_wr_idx_i),
        .res_rd_i     (res_rd_i),
        .res_rd_idx_i (res_rd_idx_i),
        .flg_wr_i     (flg_wr_i),
        .flg_wdata_i  (flg_wdata_i),
        .flag_q_o     (flag_q),
        .ovr_evt_o    (ovr_evt)
    );

    // Route events and enables into the hidden condition slots
    always_comb begin
        hid_set[HID_OVR] = ovr_evt;
        hid_set[HID_TOV] = tov_evt_i;
        hid_ie[HID_OVR]  = ovr_ie_i;
        hid_ie[HID_TOV]  = tov_ie_i;
    end

    for (genvar k = 0; k < HID_NUM; k++) begin : g_hid
        assign hid_clr[k] = vec_acc_i && hid_sel[k];
        cvt_irq_sticky u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hid_set[k]),
            .clr_i (hid_clr[k]),
            .q_o   (hid_q[k])
        );
    end

    assign flg_act = flag_q & en_q;

    cvt_irq_prio_enc #(.NUM_RES(NUM_RES)) u_enc (
        .ovr_act_i (hid_q[HID_OVR] && hid_ie[HID_OVR]),
        .tov_act_i (hid_q[HID_TOV] && hid_ie[HID_TOV]),
        .flg_act_i (flg_act),
        .vec_o     (vec),
        .sel_ovr_o (hid_sel[HID_OVR]),
        .sel_tov_o (hid_sel[HID_TOV]),
        .any_o     (any_act)
    );

    assign vec_q_o  = vec;
    assign irq_o    = gie_i && any_act;
    assign en_q_o   = en_q;
    assign flag_q_o = flag_q;
endmodule

// File: rtl/cvt_irq_vector_chk.sv
// Checker for cvt_irq_vector, bound to every instance of the top.
// Relates strobes to flags, the vector and the request over time.
module cvt_irq_vector_chk
    import cvt_irq_pkg::*;
#(
    parameter  int NUM_RES = 16,
    localparam int IDX_W   = $clog2(NUM_RES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gie_i,
    input logic               flg_wr_i,
    input logic               res_wr_i,
    input logic [IDX_W-1:0]   res_wr_idx_i,
    input logic               res_rd_i,
    input logic [IDX_W-1:0]   res_rd_idx_i,
    input logic               tov_evt_i,
    input logic               vec_acc_i,
    input logic [NUM_RES-1:0] flag_q_o,
    input logic [VEC_W-1:0]   vec_q_o,
    input logic               irq_o,
    input logic               ovr_evt
);
    a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i);

    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_q_o != CODE_NONE));

    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q_o[0] == 1'b0) && (vec_q_o <= flag_code(NUM_RES - 1)));

    a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_i |=> flag_q_o[$past(res_wr_idx_i)]);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd_i && !(res_wr_i && (res_wr_idx_i == res_rd_idx_i)))
        |=> !flag_q_o[$past(res_rd_idx_i)]);

    a_r9_flags_survive_access: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc_i && !res_wr_i && !res_rd_i && !flg_wr_i) |=> $stable(flag_q_o));

    a_r9_ovr_serviced: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc_i && (vec_q_o == CODE_OVR) && !ovr_evt) |=> (vec_q_o != CODE_OVR));

    a_r9_tov_serviced: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc_i && (vec_q_o == CODE_TOV) && !tov_evt_i) |=> (vec_q_o != CODE_TOV));
endmodule

bind cvt_irq_vector cvt_irq_vector_chk #(.NUM_RES(NUM_RES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gie_i        (gie_i),
    .flg_wr_i     (flg_wr_i),
    .res_wr_i     (res_wr_i),
    .res_wr_idx_i (res_wr_idx_i),
    .res_rd_i     (res_rd_i),
    .res_rd_idx_i (res_rd_idx_i),
    .tov_evt_i    (tov_evt_i),
    .vec_acc_i    (vec_acc_i),
    .flag_q_o     (flag_q_o),
    .vec_q_o      (vec_q_o),
    .irq_o        (irq_o),
    .ovr_evt      (ovr_evt)
);

// File: tb/sim_cvt_irq_vector.sv
// Bench for cvt_irq_vector: directed corner cases, then a random phase,
// with a behavioural reference model compared after every clock.
module sim_cvt_irq_vector;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gie = 1'b0, ovr_ie = 1'b0, tov_ie = 1'b0;
    logic          en_wr = 1'b0, flg_wr = 1'b0;
    logic [N-1:0]  en_wdata = '0, flg_wdata = '0;
    logic [N-1:0]  en_q, flag_q;
    logic          res_wr = 1'b0, res_rd = 1'b0;
    logic [IW-1:0] res_wr_idx = '0, res_rd_idx = '0;
    logic          tov_evt = 1'b0, vec_acc = 1'b0;
    logic [15:0]   vec_q;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [N-1:0] m_flag = '0, m_unread = '0, m_en = '0;
    bit           m_ovr = 0, m_tov = 0;

    always #5 clk = ~clk;

    cvt_irq_vector #(.NUM_RES(N)) u0 (
        .clk (clk), .rst_n (rst_n), .gie_i (gie), .ovr_ie_i (ovr_ie),
        .tov_ie_i (tov_ie), .en_wr_i (en_wr), .en_wdata_i (en_wdata),
        .en_q_o (en_q), .flg_wr_i (flg_wr), .flg_wdata_i (flg_wdata),
        .flag_q_o (flag_q), .res_wr_i (res_wr), .res_wr_idx_i (res_wr_idx),
        .res_rd_i (res_rd), .res_rd_idx_i (res_rd_idx), .tov_evt_i (tov_evt),
        .vec_acc_i (vec_acc), .vec_q_o (vec_q), .irq_o (irq)
    );

    function automatic logic [15:0] ref_vec();
        if (m_ovr && ovr_ie) return 16'd2;
        if (m_tov && tov_ie) return 16'd4;
        for (int n = 0; n < N; n++)
            if (m_flag[n] && m_en[n]) return 16'(6 + 2 * n);
        return 16'd0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs present at the edge
    task automatic model_step();
        logic [15:0] vcur;
        bit          new_ovr;
        vcur    = ref_vec();
        new_ovr = res_wr && m_unread[res_wr_idx] && !(res_rd && res_rd_idx == res_wr_idx);
        if (flg_wr) m_flag = flg_wdata;
        if (res_rd) begin m_flag[res_rd_idx] = 1'b0; m_unread[res_rd_idx] = 1'b0; end
        if (res_wr) begin m_flag[res_wr_idx] = 1'b1; m_unread[res_wr_idx] = 1'b1; end
        if (vec_acc && vcur == 16'd2) m_ovr = 0;
        if (vec_acc && vcur == 16'd4) m_tov = 0;
        if (new_ovr) m_ovr = 1;
        if (tov_evt) m_tov = 1;
        if (en_wr)   m_en = en_wdata;
    endtask

    task automatic compare_all();
        check("R2",  "vector",  32'(vec_q),  32'(ref_vec()));
        check("R10", "irq",     32'(irq),    32'(gie && ((m_ovr && ovr_ie) || (m_tov && tov_ie) || |(m_flag & m_en))));
        check("R5",  "flags",   32'(flag_q), 32'(m_flag));
        check("R11", "enables", 32'(en_q),   32'(m_en));
    endtask

    // One clock: model follows the edge, strobes drop, outputs compared
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        res_wr = 0; res_rd = 0; tov_evt = 0; vec_acc = 0; flg_wr = 0; en_wr = 0;
        #1;
        compare_all();
    endtask

    task automatic wr(input int i);
        res_wr = 1; res_wr_idx = IW'(i);
    endtask

    task automatic rd(input int i);
        res_rd = 1; res_rd_idx = IW'(i);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", "reset flags", 32'(flag_q), 0);
        check("R1", "reset enables", 32'(en_q), 0);
        check("R1", "reset vector", 32'(vec_q), 0);
        check("R1", "reset irq", 32'(irq), 0);

        gie = 1; ovr_ie = 1; tov_ie = 1;
        en_wr = 1; en_wdata = 16'hFFFF; cyc();
        check("R11", "enable load", 32'(en_q), 32'hFFFF);

        wr(3); cyc();
        check("R5", "flag3 set", 32'(flag_q), 32'h0008);
        check("R2", "flag3 code", 32'(vec_q), 32'h000C);
        check("R10", "irq on", 32'(irq), 1);

        wr(0); cyc();
        check("R3", "flag0 over flag3", 32'(vec_q), 32'h0006);

        wr(3); cyc();
        check("R7", "overrun on unread entry", 32'(vec_q), 32'h0002);

        tov_evt = 1; cyc();
        check("R3", "overrun over timing", 32'(vec_q), 32'h0002);

        vec_acc = 1; cyc();
        check("R9", "overrun cleared", 32'(vec_q), 32'h0004);
        check("R9", "flags kept", 32'(flag_q), 32'h0009);

        vec_acc = 1; cyc();
        check("R8", "timing cleared", 32'(vec_q), 32'h0006);
        vec_acc = 1; cyc();
        check("R9", "flag0 not cleared by access", 32'(vec_q), 32'h0006);

        en_wr = 1; en_wdata = 16'hFFFE; cyc();
        check("R4", "flag0 masked", 32'(vec_q), 32'h000C);

        ovr_ie = 0; wr(3); cyc();
        check("R4", "overrun masked", 32'(vec_q), 32'h000C);
        ovr_ie = 1; #1;
        check("R4", "overrun unmasked", 32'(vec_q), 32'h0002);
        vec_acc = 1; cyc();
        check("R9", "overrun serviced", 32'(vec_q), 32'h000C);

        rd(3); cyc();
        check("R6", "read clears flag3", 32'(flag_q), 32'h0001);
        check("R10", "irq off with only masked flag", 32'(irq), 0);
        flg_wr = 1; flg_wdata = 16'h0000; cyc();
        check("R6", "software clear", 32'(flag_q), 0);

        wr(5); cyc();
        flg_wr = 1; flg_wdata = 16'h0000; cyc();
        wr(5); cyc();
        check("R7", "software clear is not a read", 32'(vec_q), 32'h0002);
        vec_acc = 1; cyc();
        rd(5); cyc();

        wr(7); cyc();
        wr(7); rd(7); cyc();
        check("R7", "same-cycle read first", 32'(vec_q), 32'h0014);
        check("R5", "write wins over read", 32'(flag_q), 32'h0080);
        rd(7); cyc();

        tov_evt = 1; cyc();
        check("R8", "timing raised", 32'(vec_q), 32'h0004);
        tov_evt = 1; vec_acc = 1; cyc();
        check("R9", "new event beats clear", 32'(vec_q), 32'h0004);
        vec_acc = 1; cyc();
        check("R9", "timing serviced", 32'(vec_q), 0);

        wr(2); cyc();
        gie = 0; #1;
        check("R10", "gie low blocks irq", 32'(irq), 0);
        check("R2", "vector independent of gie", 32'(vec_q), 32'h000A);
        gie = 1; rd(2); cyc();

        for (int c = 0; c < 4000; c++) begin
            if (c % 200 == 0) begin
                ovr_ie = 1'($urandom); tov_ie = 1'($urandom); gie = ($urandom % 4) != 0;
            end
            res_wr = ($urandom % 3) == 0; res_wr_idx = IW'($urandom);
            res_rd = ($urandom % 3) == 0; res_rd_idx = IW'($urandom);
            tov_evt = ($urandom % 16) == 0;
            vec_acc = ($urandom % 4) == 0;
            flg_wr = ($urandom % 40) == 0; flg_wdata = 16'($urandom);
            en_wr = ($urandom % 60) == 0;  en_wdata = 16'($urandom);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule